// File: doc/BRIEF.md
# Wide Dual-Read Banked Data Memory

This block is a 256-entry data store of 64-bit words with one write port and two read ports. Internally it splits every word into two 32-bit halves kept in two narrow banks. Both banks share one address and are accessed in the same cycle. Each bank offers one read-write port and one read-only port. Read port 0 goes through the read-write ports, so it shares them with the write. Read port 1 goes through the read-only ports.

Bank reads are synchronous: the array result appears after the clock edge that samples the address. That result is then captured a second time into output flip-flops. Downstream logic therefore only ever sees a plain register, never the array's access path. A read issued in one cycle is visible on the output after the second rising edge, and both read ports have the same timing. The shared read-write port is steered by a four-way operation decode: idle, read, write, and write-with-read. A register holding the decoded operation tells the output stage whether to capture.

Top module: `wide_dual_read_mem`

## Requirements
- R1: A read on port 0 presented before rising edge N shows its word on `rd0_data` after edge N+1, not after edge N.
- R2: Port 1 has the same two-edge latency as port 0, and both ports may read different addresses in the same cycle.
- R3: A write stores `wr_data[31:0]` in bank 0 and `wr_data[63:32]` in bank 1 in the same cycle, so a later read returns the full 64-bit word with both halves in place.
- R4: When a write and reads on both ports target the same address in the same cycle, both ports return the contents from before that write.
- R5: When `wr_en` and `rd0_en` are high together, the shared read-write port uses `wr_addr`. Port 0 returns the old contents at `wr_addr`, `rd0_addr` has no effect, and port 1 is unaffected.
- R6: While a port's read enable stays low, its output register holds its value, even when the word it last returned is overwritten.
- R7: Active-low reset `rst_n` clears `rd0_data` and `rd1_data` to zero.
- R8: Reset leaves the stored words unchanged.
- R9: A read presented in the cycle right after a write to that address returns the new word.
- R10: The lowest address (0) and the highest address (255) hold independent words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 8 | Write address |
| wr_data | input | 64 | Write data |
| rd0_en | input | 1 | Port 0 read enable (shares the read-write bank ports) |
| rd0_addr | input | 8 | Port 0 read address |
| rd0_data | output | 64 | Port 0 registered read data |
| rd1_en | input | 1 | Port 1 read enable (read-only bank ports) |
| rd1_addr | input | 8 | Port 1 read address |
| rd1_data | output | 64 | Port 1 registered read data |

## Verification
The assertions assume that every input is free of X and settles away from the rising edge. The hold checks also assume that read enables stay low during reset, so a value seen two cycles back is never a read left over from the reset window. The bench drives all inputs on falling edges and keeps every enable at zero while `rst_n` is low. It sets up the two-ports-on-one-address cases only with known array contents, so the equality properties compare defined data.

// File: rtl/wdr_pkg.sv
package wdr_pkg;

    // Operation presented to the shared read-write bank ports in one cycle
    typedef enum logic [1:0] {
        PA_IDLE       = 2'd0,
        PA_READ       = 2'd1,
        PA_WRITE      = 2'd2,
        PA_WRITE_READ = 2'd3
    } porta_op_e;

endpackage

// File: rtl/wdr_bank.sv
// One narrow bank: a read-write port (a) and a read-only port (b),
// both with synchronous read. The read sees the contents from before a same-cycle write.
module wdr_bank #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_we,
    input  logic              a_re,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_re,
    input  logic [ADDR_W-1:0] b_addr,
    output logic [DATA_W-1:0] b_rdata
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (a_we) begin
            cells[a_addr] <= a_wdata;
        end
        if (a_re) begin
            a_rdata <= cells[a_addr];
        end
        if (b_re) begin
            b_rdata <= cells[b_addr];
        end
    end

endmodule

// File: rtl/wdr_out_reg.sv
// Second register stage after the bank read; loads only when a read was issued.
module wdr_out_reg #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/wide_dual_read_mem.sv
module wide_dual_read_mem
    import wdr_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int HALF_W    = 32,
    parameter int NUM_BANKS = 2,
    localparam int WORD_W   = HALF_W * NUM_BANKS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd0_en,
    input  logic [ADDR_W-1:0] rd0_addr,
    output logic [WORD_W-1:0] rd0_data,
    input  logic              rd1_en,
    input  logic [ADDR_W-1:0] rd1_addr,
    output logic [WORD_W-1:0] rd1_data
);

    porta_op_e         op_d;
    porta_op_e         op_q;
    logic              rd1_issued_q;
    logic [ADDR_W-1:0] pa_addr;
    logic              pa_we;
    logic              pa_re;
    logic              cap0;
    logic [WORD_W-1:0] bank_a_rdata;
    logic [WORD_W-1:0] bank_b_rdata;

    // Decode of the shared read-write port operation
    always_comb begin
        unique case ({wr_en, rd0_en})
            2'b00: op_d = PA_IDLE;
            2'b01: op_d = PA_READ;
            2'b10: op_d = PA_WRITE;
            2'b11: op_d = PA_WRITE_READ;
        endcase
    end

    // State register: operation issued last cycle, per port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q         <= PA_IDLE;
            rd1_issued_q <= 1'b0;
        end else begin
            op_q         <= op_d;
            rd1_issued_q <= rd1_en;
        end
    end

    // Outputs of the decode: bank port controls and output-stage load
    always_comb begin
        pa_addr = rd0_addr;
        pa_we   = 1'b0;
        pa_re   = 1'b0;
        unique case (op_d)
            PA_IDLE: begin
            end
            PA_READ: begin
                pa_re = 1'b1;
            end
            PA_WRITE: begin
                pa_addr = wr_addr;
                pa_we   = 1'b1;
            end
            PA_WRITE_READ: begin
                pa_addr = wr_addr;
                pa_we   = 1'b1;
                pa_re   = 1'b1;
            end
        endcase
        cap0 = (op_q == PA_READ) || (op_q == PA_WRITE_READ);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        wdr_bank #(
            .ADDR_W (ADDR_W),
            .DATA_W (HALF_W)
        ) u_bank (
            .clk     (clk),
            .a_addr  (pa_addr),
            .a_we    (pa_we),
            .a_re    (pa_re),
            .a_wdata (wr_data[b*HALF_W +: HALF_W]),
            .a_rdata (bank_a_rdata[b*HALF_W +: HALF_W]),
            .b_re    (rd1_en),
            .b_addr  (rd1_addr),
            .b_rdata (bank_b_rdata[b*HALF_W +: HALF_W])
        );
    end

    wdr_out_reg #(.WIDTH(WORD_W)) u_out0 (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cap0),
        .d     (bank_a_rdata),
        .q     (rd0_data)
    );

    wdr_out_reg #(.WIDTH(WORD_W)) u_out1 (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (rd1_issued_q),
        .d     (bank_b_rdata),
        .q     (rd1_data)
    );

endmodule

// File: rtl/wdr_checker.sv
module wdr_checker #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              rd0_en,
    input logic [ADDR_W-1:0] rd0_addr,
    input logic [WORD_W-1:0] rd0_data,
    input logic              rd1_en,
    input logic [ADDR_W-1:0] rd1_addr,
    input logic [WORD_W-1:0] rd1_data
);

    // R7: the first edge after reset release sees cleared outputs
    p_reset_clear_r7: assert property (@(posedge clk)
        $rose(rst_n) |-> (rd0_data == '0) && (rd1_data == '0));

    // R6: port 0 holds without reads
    p_hold0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rd0_en) && !$past(rd0_en, 2) && $past(rst_n)) |-> $stable(rd0_data));

    // R6: port 1 holds without reads
    p_hold1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rd1_en) && !$past(rd1_en, 2) && $past(rst_n)) |-> $stable(rd1_data));

    // R2: same address on both ports, no write -> same data, same cycle
    p_same_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(rd0_en, 2) && $past(rd1_en, 2) && !$past(wr_en, 2)
         && ($past(rd0_addr, 2) == $past(rd1_addr, 2))) |-> (rd0_data == rd1_data));

    // R4: collision with a write -> both ports report the same (old) word
    p_collide_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(wr_en, 2) && $past(rd0_en, 2) && $past(rd1_en, 2)
         && ($past(rd1_addr, 2) == $past(wr_addr, 2))) |-> (rd0_data == rd1_data));

endmodule

bind wide_dual_read_mem wdr_checker #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W)
) u_wdr_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .rd0_en   (rd0_en),
    .rd0_addr (rd0_addr),
    .rd0_data (rd0_data),
    .rd1_en   (rd1_en),
    .rd1_addr (rd1_addr),
    .rd1_data (rd1_data)
);

// File: tb/wide_dual_read_mem_tb.sv
module wide_dual_read_mem_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic        rd0_en = 1'b0;
    logic [7:0]  rd0_addr = '0;
    logic [63:0] rd0_data;
    logic        rd1_en = 1'b0;
    logic [7:0]  rd1_addr = '0;
    logic [63:0] rd1_data;

    int n_vec = 0;
    int n_bad = 0;
    bit reported = 1'b0;
    logic [63:0] ref_mem [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    wide_dual_read_mem u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd0_en   (rd0_en),
        .rd0_addr (rd0_addr),
        .rd0_data (rd0_data),
        .rd1_en   (rd1_en),
        .rd1_addr (rd1_addr),
        .rd1_data (rd1_data)
    );

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        end
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        ref_mem[a] = d;
    endtask

    // Issue reads in one cycle and sample after the second edge
    task automatic do_read(input logic e0, input logic [7:0] a0,
                           input logic e1, input logic [7:0] a1);
        @(negedge clk);
        rd0_en = e0; rd0_addr = a0; rd1_en = e1; rd1_addr = a1;
        @(negedge clk);
        rd0_en = 1'b0; rd1_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk("R7 reset port0", rd0_data, 64'h0);
        chk("R7 reset port1", rd1_data, 64'h0);
    endtask

    task automatic t_halves_and_ends();
        do_write(8'd0,   64'h1111_2222_3333_4444);
        do_write(8'd255, 64'hFEDC_BA98_7654_3210);
        do_write(8'd17,  64'hDEAD_BEEF_0BAD_F00D);
        do_read(1'b1, 8'd17, 1'b1, 8'd17);
        chk("R3 halves port0", rd0_data, ref_mem[17]);
        chk("R3 halves port1", rd1_data, ref_mem[17]);
        do_read(1'b1, 8'd0, 1'b1, 8'd255);
        chk("R10 addr 0", rd0_data, ref_mem[0]);
        chk("R10 addr 255", rd1_data, ref_mem[255]);
    endtask

    task automatic t_latency();
        logic [63:0] prev0;
        logic [63:0] prev1;
        prev0 = rd0_data;
        prev1 = rd1_data;
        @(negedge clk);
        rd0_en = 1'b1; rd0_addr = 8'd255; rd1_en = 1'b1; rd1_addr = 8'd0;
        @(negedge clk);
        rd0_en = 1'b0; rd1_en = 1'b0;
        chk("R1 port0 not after one edge", rd0_data, prev0);
        chk("R2 port1 not after one edge", rd1_data, prev1);
        @(negedge clk);
        chk("R1 port0 after two edges", rd0_data, ref_mem[255]);
        chk("R2 port1 after two edges", rd1_data, ref_mem[0]);
    endtask

    task automatic t_collide();
        logic [63:0] old;
        old = ref_mem[17];
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'd17; wr_data = 64'hA5A5_0000_5A5A_FFFF;
        rd0_en = 1'b1; rd0_addr = 8'd17; rd1_en = 1'b1; rd1_addr = 8'd17;
        @(negedge clk);
        wr_en = 1'b0; rd0_en = 1'b0; rd1_en = 1'b0;
        ref_mem[17] = 64'hA5A5_0000_5A5A_FFFF;
        // R9: read right in the cycle after the write
        rd0_en = 1'b1; rd0_addr = 8'd17; rd1_en = 1'b1; rd1_addr = 8'd17;
        @(negedge clk);
        rd0_en = 1'b0; rd1_en = 1'b0;
        chk("R4 port0 old word", rd0_data, old);
        chk("R4 port1 old word", rd1_data, old);
        @(negedge clk);
        chk("R9 port0 new word", rd0_data, ref_mem[17]);
        chk("R9 port1 new word", rd1_data, ref_mem[17]);
    endtask

    task automatic t_shared_port();
        logic [63:0] old;
        old = ref_mem[0];
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'd0; wr_data = 64'h0F0F_0F0F_F0F0_F0F0;
        rd0_en = 1'b1; rd0_addr = 8'd255; rd1_en = 1'b1; rd1_addr = 8'd255;
        @(negedge clk);
        wr_en = 1'b0; rd0_en = 1'b0; rd1_en = 1'b0;
        ref_mem[0] = 64'h0F0F_0F0F_F0F0_F0F0;
        @(negedge clk);
        chk("R5 port0 old word at wr_addr", rd0_data, old);
        chk("R5 port1 unaffected", rd1_data, ref_mem[255]);
        do_read(1'b1, 8'd0, 1'b0, 8'd0);
        chk("R5 write landed", rd0_data, ref_mem[0]);
    endtask

    task automatic t_hold();
        logic [63:0] held0;
        logic [63:0] held1;
        do_read(1'b1, 8'd255, 1'b1, 8'd17);
        held0 = rd0_data;
        held1 = rd1_data;
        do_write(8'd255, 64'h7777_8888_9999_AAAA);
        do_write(8'd17,  64'h1234_5678_9ABC_DEF0);
        repeat (3) @(negedge clk);
        chk("R6 port0 holds", rd0_data, held0);
        chk("R6 port1 holds", rd1_data, held1);
    endtask

    task automatic t_reset_keeps_array();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R7 port0 cleared", rd0_data, 64'h0);
        chk("R7 port1 cleared", rd1_data, 64'h0);
        rst_n = 1'b1;
        do_read(1'b1, 8'd255, 1'b1, 8'd17);
        chk("R8 port0 array kept", rd0_data, ref_mem[255]);
        chk("R8 port1 array kept", rd1_data, ref_mem[17]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_halves_and_ends();
        t_latency();
        t_collide();
        t_shared_port();
        t_hold();
        t_reset_keeps_array();
        report();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
        $finish;
    end

endmodule